// File: doc/BRIEF.md
# Reverse Byte Channel Receiver (Host Side)

This block is the host end of a bidirectional parallel port running in reverse byte transfer. While its mode input is held high it takes bytes from the peripheral over the eight data lines, one at a time. It signals readiness on a busy output. It waits for the peripheral's clock, latches the byte, and answers with a strobe. The strobe is released only when the byte has been consumed, the peripheral has let go of its clock, and a minimum strobe width has passed. At that moment the data-available line decides whether another byte follows or the block goes idle.

A consumer, which may be a CPU or a DMA engine, watches the `dreq` flag and takes the byte from `rx_data` with a one-cycle read pulse. A single programmable cycle count, `min_cycles`, sets two times: the settling delay after the mode is entered, and the shortest time the strobe is held low. The peripheral's clock and data-available inputs pass through a two-flop synchronizer. The data bus is sampled one cycle after the synchronized clock is seen low, so the peripheral must hold the bus steady around its clock edge.

Top module: `rev_byte_rx`

## Requirements
- R1: While reset is low and after it is released, `host_busy_n`=1, `host_clk_n`=1, `dreq`=0, `idle`=0 and `dir_force_in`=0.
- R2: When `mode_en` rises, `dir_force_in` goes to 1 and `idle` to 0 on the first clock edge that sees it. `host_busy_n` falls on exactly the (`min_cycles`+2)th rising edge, counting that first edge as one.
- R3: At the start of every byte, `host_busy_n` is low while `host_clk_n` is high, and it stays that way until the peripheral clock `ptr_clk_n` (active low) is driven low.
- R4: After `ptr_clk_n` falls, and on a single clock edge, `rx_data` takes the value of `pdata_in`, `dreq` goes to 1, `host_busy_n` goes to 1 and `host_clk_n` goes to 0.
- R5: `host_clk_n` stays low for as long as `dreq` is 1.
- R6: `host_clk_n` stays low for as long as `ptr_clk_n` is low.
- R7: `host_clk_n` is low for at least `min_cycles`+1 clock cycles. When the byte has been read and `ptr_clk_n` has returned high early enough, it is low for exactly `min_cycles`+1 cycles.
- R8: When `host_clk_n` rises, the block looks at `data_avail_n` (active low). If it is low, `host_busy_n` goes low again for the next byte and `idle` stays 0. If it is high, `idle` goes to 1 and `host_busy_n` stays high.
- R9: A one-cycle `rd_strobe` while `dreq`=1 clears `dreq`. A `rd_strobe` while `dreq`=0 leaves both `dreq` and `rx_data` unchanged.
- R10: When `mode_en` goes low in any state, `host_busy_n`=1, `host_clk_n`=1 and `dir_force_in`=0 from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Reverse byte mode selected |
| min_cycles | input | 16 | Start delay and minimum strobe low time, in clocks |
| ptr_clk_n | input | 1 | Peripheral clock, active low, asynchronous |
| data_avail_n | input | 1 | Peripheral has more data, active low, asynchronous |
| pdata_in | input | 8 | Data bus from the pins |
| rd_strobe | input | 1 | Consumer read pulse |
| host_busy_n | output | 1 | Host busy / ready line, low means ready |
| host_clk_n | output | 1 | Host strobe, active low |
| dir_force_in | output | 1 | Forces the data pads to input |
| rx_data | output | 8 | Last received byte |
| dreq | output | 1 | A byte is waiting to be read |
| idle | output | 1 | Peripheral reported no more data |

## Verification
The hardest situation to reach is the three-way join that ends each strobe. From the outside, one condition has to be held off while the other two are already met. The stimulus does this in three runs. In the first it reads the byte at once but keeps the peripheral clock low for many cycles. In the second it releases the clock at once but delays the read. In the third it sets a long minimum width and meets both other conditions right away, so the strobe width shows the timer alone. A further test drops the mode in the middle of a strobe and checks that the lines return to their idle levels.

// File: rtl/rev_byte_pkg.sv
// Shared types for the reverse byte channel receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package rev_byte_pkg;
    typedef enum logic [2:0] {
        ST_OFF,     // mode not selected, lines released
        ST_START,   // settling delay after entry
        ST_ASK,     // busy low, waiting for peripheral clock low
        ST_LATCH,   // capture step
        ST_HOLD,    // strobe low, waiting for the three-way join
        ST_DONE     // no more data, idle flag set
    } rbr_state_e;
endpackage

// File: rtl/rbr_sync.sv
// Multi-stage synchronizer for asynchronous active-low control inputs.
// Assumes: inputs are level signals that are held far longer than STAGES clocks;
// resets to all ones (the inactive level of the lines).
module rbr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] q_r;
            if (s == 0) begin : g_first
                // first stage samples the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) q_r <= '1;
                    else        q_r <= d;
                end
            end else begin : g_next
                // later stages follow the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) q_r <= '1;
                    else        q_r <= g_stage[s-1].q_r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/rbr_min_timer.sv
// Down-counter that measures a minimum number of clocks.
// Assumes: load has priority; done is high whenever the count has reached zero.
module rbr_min_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             done
);
    logic [TMR_W-1:0] cnt_q;

    // count down from the loaded value, stop at zero
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R7
    tmr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);
    // R7
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/rbr_ctrl.sv
// Handshake sequencer for reverse byte transfer: readiness, capture,
// strobe join and continue/idle decision.
// Assumes: ack_s and avail_s are already synchronized; pdata is stable
// while the peripheral clock is low.
module rbr_ctrl
    import rev_byte_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              ack_s,
    input  logic              avail_s,
    input  logic [DATA_W-1:0] data_in,
    input  logic              rd_strobe,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic              host_busy_n,
    output logic              host_clk_n,
    output logic              dir_force_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              dreq,
    output logic              idle
);
    rbr_state_e state_q;
    logic       join_ok;

    // the timer restarts on mode entry and on every capture
    always_comb begin
        tmr_load = mode_en && ((state_q == ST_OFF) || (state_q == ST_LATCH));
    end

    // the three conditions that end a strobe
    always_comb begin
        join_ok = !dreq && ack_s && tmr_done;
    end

    // main sequencer and line drivers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_OFF;
            host_busy_n  <= 1'b1;
            host_clk_n   <= 1'b1;
            dir_force_in <= 1'b0;
            rx_data      <= '0;
            idle         <= 1'b0;
        end else if (!mode_en) begin
            state_q      <= ST_OFF;
            host_busy_n  <= 1'b1;
            host_clk_n   <= 1'b1;
            dir_force_in <= 1'b0;
        end else begin
            case (state_q)
                ST_OFF: begin
                    state_q      <= ST_START;
                    dir_force_in <= 1'b1;
                    idle         <= 1'b0;
                end
                ST_START: begin
                    if (tmr_done) begin
                        state_q     <= ST_ASK;
                        host_busy_n <= 1'b0;
                    end
                end
                ST_ASK: begin
                    if (!ack_s) state_q <= ST_LATCH;
                end
                ST_LATCH: begin
                    rx_data     <= data_in;
                    host_busy_n <= 1'b1;
                    host_clk_n  <= 1'b0;
                    state_q     <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (join_ok) begin
                        host_clk_n <= 1'b1;
                        if (!avail_s) begin
                            state_q     <= ST_ASK;
                            host_busy_n <= 1'b0;
                        end else begin
                            state_q <= ST_DONE;
                            idle    <= 1'b1;
                        end
                    end
                end
                ST_DONE: state_q <= ST_DONE;
                default: state_q <= ST_OFF;
            endcase
        end
    end

    // byte-waiting flag: set on capture, cleared by a read
    always_ff @(posedge clk) begin
        if (!rst_n)                              dreq <= 1'b0;
        else if (mode_en && state_q == ST_LATCH) dreq <= 1'b1;
        else if (rd_strobe && dreq)              dreq <= 1'b0;
    end

    // R3
    busy_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!host_busy_n && !host_clk_n));
    // R4
    dreq_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dreq) |-> $fell(host_clk_n));
    // R7
    strobe_min_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_clk_n) && $past(mode_en)) |-> $past(tmr_done));
    // R5
    strobe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_clk_n) && $past(mode_en)) |-> !$past(dreq));
    // R8
    idle_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $rose(host_clk_n));
    // R10
    mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (host_busy_n && host_clk_n && !dir_force_in));
endmodule

// File: rtl/rev_byte_rx.sv
// Top of the reverse byte channel receiver: synchronizer, minimum-time
// timer and handshake sequencer.
// Assumes: ptr_clk_n and data_avail_n are asynchronous; min_cycles is
// changed only while mode_en is low.
module rev_byte_rx #(
    parameter int DATA_W      = 8,
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic [TMR_W-1:0]  min_cycles,
    input  logic              ptr_clk_n,
    input  logic              data_avail_n,
    input  logic [DATA_W-1:0] pdata_in,
    input  logic              rd_strobe,
    output logic              host_busy_n,
    output logic              host_clk_n,
    output logic              dir_force_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              dreq,
    output logic              idle
);
    localparam int CTRL_IN_W = 2;

    logic [CTRL_IN_W-1:0] raw_ctrl;
    logic [CTRL_IN_W-1:0] sync_ctrl;
    logic                 tmr_load;
    logic                 tmr_done;

    assign raw_ctrl = {data_avail_n, ptr_clk_n};

    rbr_sync #(.WIDTH(CTRL_IN_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_ctrl),
        .q     (sync_ctrl)
    );

    rbr_min_timer #(.TMR_W(TMR_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (min_cycles),
        .done     (tmr_done)
    );

    rbr_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_en      (mode_en),
        .ack_s        (sync_ctrl[0]),
        .avail_s      (sync_ctrl[1]),
        .data_in      (pdata_in),
        .rd_strobe    (rd_strobe),
        .tmr_done     (tmr_done),
        .tmr_load     (tmr_load),
        .host_busy_n  (host_busy_n),
        .host_clk_n   (host_clk_n),
        .dir_force_in (dir_force_in),
        .rx_data      (rx_data),
        .dreq         (dreq),
        .idle         (idle)
    );
endmodule

// File: tb/rev_byte_rx_tb_top.sv
module rev_byte_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_en = 1'b0;
    logic [15:0] min_cycles = 16'd0;
    logic        ptr_clk_n = 1'b1;
    logic        data_avail_n = 1'b1;
    logic [7:0]  pdata_in = 8'h00;
    logic        rd_strobe = 1'b0;
    logic        host_busy_n, host_clk_n, dir_force_in, dreq, idle;
    logic [7:0]  rx_data;

    int n_chk = 0;
    int n_fail = 0;
    int low_cur = 0;
    int low_last = 0;
    bit done_run = 0;

    always #5 clk = ~clk;

    rev_byte_rx dut_i (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .min_cycles(min_cycles),
        .ptr_clk_n(ptr_clk_n), .data_avail_n(data_avail_n), .pdata_in(pdata_in),
        .rd_strobe(rd_strobe), .host_busy_n(host_busy_n), .host_clk_n(host_clk_n),
        .dir_force_in(dir_force_in), .rx_data(rx_data), .dreq(dreq), .idle(idle)
    );

    // strobe low-width monitor, sampled between edges
    always @(negedge clk) begin
        if (!host_clk_n) low_cur = low_cur + 1;
        else if (low_cur != 0) begin
            low_last = low_cur;
            low_cur  = 0;
        end
    end

    typedef struct packed {
        logic [15:0] mc;
        logic [7:0]  d0;
        logic [7:0]  d1;
        logic [7:0]  rdly;
        logic [7:0]  ackh;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{16'd0,  8'hA5, 8'h3C, 8'd0, 8'd0},
        '{16'd1,  8'h00, 8'hFF, 8'd2, 8'd1},
        '{16'd5,  8'h5A, 8'hC3, 8'd0, 8'd6},
        '{16'd12, 8'h81, 8'h7E, 8'd9, 8'd0},
        '{16'd3,  8'h12, 8'h34, 8'd4, 8'd4}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wait_busy(input logic lvl, input string req);
        int t = 0;
        while (host_busy_n !== lvl && t < 2000) begin @(negedge clk); t++; end
        chk(host_busy_n === lvl, req, int'(host_busy_n), int'(lvl));
    endtask

    task automatic wait_hclk(input logic lvl, input string req);
        int t = 0;
        while (host_clk_n !== lvl && t < 2000) begin @(negedge clk); t++; end
        chk(host_clk_n === lvl, req, int'(host_clk_n), int'(lvl));
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    // enter the mode and measure the delay to the first readiness (R2)
    task automatic enter_mode(input int mc);
        int edges = 0;
        @(negedge clk);
        min_cycles = 16'(mc);
        mode_en = 1'b1;
        while (edges < 5000) begin
            @(posedge clk); edges++;
            @(negedge clk);
            if (edges == 1) begin
                chk(dir_force_in === 1'b1, "R2 dir_force", int'(dir_force_in), 1);
                chk(idle === 1'b0, "R2 idle cleared", int'(idle), 0);
            end
            if (host_busy_n === 1'b0) break;
        end
        chk(edges == mc + 2, "R2 start delay", edges, mc + 2);
    endtask

    task automatic leave_mode();
        @(negedge clk);
        mode_en = 1'b0;
        @(negedge clk);
        chk(host_busy_n && host_clk_n && !dir_force_in, "R10 lines released",
            {host_busy_n, host_clk_n, dir_force_in}, 3'b110);
    endtask

    // one peripheral byte with read delay and clock hold times
    task automatic do_byte(input logic [7:0] d, input bit last, input int rdly,
                           input int ackh, input int mc);
        wait_busy(1'b0, "R3 busy low for byte");
        chk(host_clk_n === 1'b1, "R3 strobe high while ready", int'(host_clk_n), 1);
        pdata_in = d;
        data_avail_n = last;
        repeat (3) @(negedge clk);
        chk(host_busy_n === 1'b0, "R3 ready held", int'(host_busy_n), 0);
        ptr_clk_n = 1'b0;
        wait_hclk(1'b0, "R4 strobe falls");
        chk(host_busy_n === 1'b1 && dreq === 1'b1, "R4 busy high and dreq",
            {host_busy_n, dreq}, 2'b11);
        chk(rx_data === d, "R4 captured byte", int'(rx_data), int'(d));
        repeat (ackh) @(negedge clk);
        ptr_clk_n = 1'b1;
        repeat (rdly) @(negedge clk);
        pulse_rd();
        wait_hclk(1'b1, "R5 strobe rises");
        @(negedge clk);
        chk(low_last >= mc + 1, "R7 minimum width", low_last, mc + 1);
        @(negedge clk);
        if (last) begin
            repeat (3) @(negedge clk);
            chk(idle === 1'b1 && host_busy_n === 1'b1, "R8 idle after last",
                {idle, host_busy_n}, 2'b11);
        end else begin
            chk(idle === 1'b0, "R8 continue without idle", int'(idle), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state during and after reset
        chk({host_busy_n, host_clk_n, dreq, idle, dir_force_in} === 5'b11000,
            "R1 in reset", {host_busy_n, host_clk_n, dreq, idle, dir_force_in}, 5'b11000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({host_busy_n, host_clk_n, dreq, idle, dir_force_in} === 5'b11000,
            "R1 after reset", {host_busy_n, host_clk_n, dreq, idle, dir_force_in}, 5'b11000);

        // table walk: two bytes per session
        for (int v = 0; v < 5; v++) begin
            enter_mode(int'(VECS[v].mc));
            do_byte(VECS[v].d0, 1'b0, int'(VECS[v].rdly), int'(VECS[v].ackh), int'(VECS[v].mc));
            do_byte(VECS[v].d1, 1'b1, int'(VECS[v].rdly), int'(VECS[v].ackh), int'(VECS[v].mc));
            leave_mode();
        end

        // R2: re-entry clears idle (idle was left set by the last session)
        chk(idle === 1'b1, "R2 idle kept while off", int'(idle), 1);
        enter_mode(3);

        // R6: read at once, hold peripheral clock low for long
        pdata_in = 8'hC9; data_avail_n = 1'b0;
        repeat (3) @(negedge clk);
        ptr_clk_n = 1'b0;
        wait_hclk(1'b0, "R4 strobe falls join test");
        pulse_rd();
        repeat (30) @(negedge clk);
        chk(host_clk_n === 1'b0, "R6 strobe held by peripheral clock", int'(host_clk_n), 0);
        ptr_clk_n = 1'b1;
        wait_hclk(1'b1, "R6 strobe released");

        // R9: read while dreq clear has no effect
        wait_busy(1'b0, "R8 next byte requested");
        pulse_rd();
        @(negedge clk);
        chk(dreq === 1'b0 && rx_data === 8'hC9, "R9 stray read ignored",
            int'(rx_data), 8'hC9);

        // R5: peripheral clock released at once, read delayed
        pdata_in = 8'h66;
        ptr_clk_n = 1'b0;
        wait_hclk(1'b0, "R4 strobe falls read test");
        @(negedge clk);
        ptr_clk_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(host_clk_n === 1'b0 && dreq === 1'b1, "R5 strobe held by unread byte",
            {host_clk_n, dreq}, 2'b01);
        pulse_rd();
        chk(dreq === 1'b0, "R9 read clears dreq", int'(dreq), 0);
        wait_hclk(1'b1, "R5 strobe released");
        leave_mode();

        // R7: exact width when only the timer gates the strobe
        enter_mode(20);
        pdata_in = 8'h99; data_avail_n = 1'b0;
        repeat (3) @(negedge clk);
        ptr_clk_n = 1'b0;
        wait_hclk(1'b0, "R4 strobe falls width test");
        ptr_clk_n = 1'b1;
        pulse_rd();
        wait_hclk(1'b1, "R7 strobe rises");
        @(negedge clk);
        chk(low_last == 21, "R7 exact width", low_last, 21);

        // R10: leave the mode in the middle of a strobe
        wait_busy(1'b0, "R8 ready again");
        pdata_in = 8'h42;
        ptr_clk_n = 1'b0;
        wait_hclk(1'b0, "R4 strobe falls exit test");
        mode_en = 1'b0;
        @(negedge clk);
        chk(host_busy_n && host_clk_n && !dir_force_in, "R10 exit mid strobe",
            {host_busy_n, host_clk_n, dir_force_in}, 3'b110);
        ptr_clk_n = 1'b1;
        pulse_rd();
        chk(dreq === 1'b0 && rx_data === 8'h42, "R9 late read after exit",
            int'(rx_data), 8'h42);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule